// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block gives software control over a wide set of general-purpose pins, split into banks of 32. For every bank it holds a direction word and an output word. It samples the pins through a two-stage synchroniser and records rising and falling transitions in a sticky status word. The output word changes only through two write-only strobes: one sets bits and one clears bits. A read-modify-write of the outputs is therefore never needed.

All banks sit behind one 32-bit register port with single-cycle writes and registered reads. The registers are grouped by kind, and the three lowest banks fill adjacent words inside each group. Higher banks use a second window that repeats the same group layout. Each status bit has a mask bit. A registered interrupt line is raised while any unmasked status bit is pending.

Top module: `banked_gpio`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), every output is 0, `irq` is 0, and the rising-enable, falling-enable, status and mask registers all read 0.
- R2: Writing a 1 to a bit of the set register (group 0x18) drives that output high. Writing a 1 to a bit of the clear register (group 0x24) drives it low. Zero bits leave the output unchanged. Both registers read as 0.
- R3: A direction bit (group 0x0C) of 1 enables the pin's output driver and a 0 makes the pin an input. The register reads back as written.
- R4: The level register (group 0x00) returns the pin inputs after two synchronising flops, whatever the pin direction.
- R5: A status bit (group 0x48) is set on a 0-to-1 transition of the synchronised input when its rising-enable bit (group 0x30) is 1. It is set on a 1-to-0 transition when its falling-enable bit (group 0x3C) is 1.
- R6: Status bits stay set until a 1 is written to them. Writing 0 changes nothing, and writing all ones clears every pending bit.
- R7: When a new enabled edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit remains set.
- R8: `irq` is a register that is 1 exactly when some status bit has its mask bit (group 0x9C) set, one cycle after the status and mask settle.
- R9: A register's address is its group offset plus its bank offset. For bank n < 3 the bank offset is n*4. For n >= 3 it is 0x100 + (n-3)*4.
- R10: In the last bank, bits above the implemented pin count read 0 and ignore writes.
- R11: Reads of addresses that hold no register return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, 0 when no read is taking place |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output driver enables |
| irq | output | 1 | Registered interrupt request |

## Verification
Edge capture and software clearing of the status word can land in the same cycle. That case is provoked by raising a pin exactly two cycles before a write-one-to-clear of its status bit. With that timing, the synchronised transition and the write commit on the same clock edge. A later read of the status word must still show the bit. A design that gives the clear priority loses the event and reads 0.

// File: rtl/banked_gpio.sv
module banked_gpio #(
  parameter int NUM_PINS = 100,
  parameter int ADDR_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int NB = (NUM_PINS + 31) / 32;
  localparam int W  = NB * 32;

  function automatic logic [31:0] vmask(int b);
    return (b == NB - 1) ? (32'hFFFF_FFFF >> (W - NUM_PINS)) : 32'hFFFF_FFFF;
  endfunction

  function automatic int grp(int t);
    case (t)
      0: return 'h00;  1: return 'h0C;  2: return 'h18;  3: return 'h24;
      4: return 'h30;  5: return 'h3C;  6: return 'h48;  default: return 'h9C;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] ra(int t, int b);
    return ADDR_W'(grp(t) + ((b < 3) ? b * 4 : 'h100 + (b - 3) * 4));
  endfunction

  logic [31:0] dir_q [NB];
  logic [31:0] out_q [NB];
  logic [31:0] ren_q [NB];
  logic [31:0] fen_q [NB];
  logic [31:0] st_q  [NB];
  logic [31:0] msk_q [NB];
  logic [W-1:0] pad, s1, s2, s3, rise, fall, out_flat, oe_flat;
  logic [31:0] rd_val;
  logic        irq_d;

  always_comb begin
    pad = '0;
    pad[NUM_PINS-1:0] = pin_in;
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pad; s2 <= s1; s3 <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        dir_q[b] <= '0; out_q[b] <= '0; ren_q[b] <= '0;
        fen_q[b] <= '0; st_q[b]  <= '0; msk_q[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (bus_wr && bus_addr == ra(1, b)) dir_q[b] <= bus_wdata & vmask(b);
        if (bus_wr && bus_addr == ra(4, b)) ren_q[b] <= bus_wdata & vmask(b);
        if (bus_wr && bus_addr == ra(5, b)) fen_q[b] <= bus_wdata & vmask(b);
        if (bus_wr && bus_addr == ra(7, b)) msk_q[b] <= bus_wdata & vmask(b);
        if (bus_wr && bus_addr == ra(2, b))
          out_q[b] <= out_q[b] | (bus_wdata & vmask(b));
        else if (bus_wr && bus_addr == ra(3, b))
          out_q[b] <= out_q[b] & ~bus_wdata;
        st_q[b] <= (st_q[b] & ~((bus_wr && bus_addr == ra(6, b)) ? bus_wdata : 32'h0))
                 | (((rise[32*b +: 32] & ren_q[b]) | (fall[32*b +: 32] & fen_q[b])) & vmask(b));
      end
    end

  always_comb begin
    rd_val = '0;
    irq_d  = 1'b0;
    for (int b = 0; b < NB; b++) begin
      out_flat[32*b +: 32] = out_q[b];
      oe_flat[32*b +: 32]  = dir_q[b];
      irq_d = irq_d | (|(st_q[b] & msk_q[b]));
      if (bus_addr == ra(0, b)) rd_val = s2[32*b +: 32] & vmask(b);
      if (bus_addr == ra(1, b)) rd_val = dir_q[b];
      if (bus_addr == ra(4, b)) rd_val = ren_q[b];
      if (bus_addr == ra(5, b)) rd_val = fen_q[b];
      if (bus_addr == ra(6, b)) rd_val = st_q[b];
      if (bus_addr == ra(7, b)) rd_val = msk_q[b];
    end
  end

  assign pin_out = out_flat[NUM_PINS-1:0];
  assign pin_oe  = oe_flat[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : 32'h0;
      irq       <= irq_d;
    end
endmodule

// File: rtl/banked_gpio_chk.sv
module banked_gpio_chk #(
  parameter int NUM_PINS = 100,
  parameter int ADDR_W   = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!irq && pin_oe == '0 && pin_out == '0)); // R1
  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h18) && bus_wdata[0]) |=> pin_out[0]); // R2
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h24) && bus_wdata[0]) |=> !pin_out[0]); // R2
  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADDR_W'('h18) || bus_addr == ADDR_W'('h24))) |=> bus_rdata == 32'h0); // R2
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h0C)) |=> pin_oe[31:0] == $past(bus_wdata)); // R3
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h60)) |=> bus_rdata == 32'h0); // R11
endmodule

bind banked_gpio banked_gpio_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq)
);

// File: tb/banked_gpio_tb_top.sv
`timescale 1ns/1ps
module banked_gpio_tb_top;
  localparam int NP = 100;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe, ext = '0;
  logic          irq;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  banked_gpio #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  always #2 clk = ~clk;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic rd_q = 1'b0;
  bit done = 0;

  always @(posedge clk) rd_q <= bus_rd;

  always @(negedge clk) begin
    if (rd_q && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] e, string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(32'(pin_oe[31:0]), 32'h0, "R1 oe");
    chk(32'(pin_out[31:0]), 32'h0, "R1 out");
    chk(32'(irq), 32'h0, "R1 irq");
    rd('h48, 32'h0, "R1 status");
    rd('h30, 32'h0, "R1 rise enable");
    rd('h9C, 32'h0, "R1 mask");
    // R3 direction
    wr('h0C, 32'h0000_00FF);
    chk(32'(pin_oe[31:0]), 32'h0000_00FF, "R3 oe");
    rd('h0C, 32'h0000_00FF, "R3 readback");
    // R2 set / clear strobes
    wr('h18, 32'h0000_000F);
    chk(32'(pin_out[7:0]), 32'h0F, "R2 set");
    wr('h18, 32'h0);
    chk(32'(pin_out[7:0]), 32'h0F, "R2 zero write");
    wr('h24, 32'h0000_0003);
    chk(32'(pin_out[7:0]), 32'h0C, "R2 clear");
    rd('h18, 32'h0, "R2 set reads zero");
    // R4 level through synchroniser
    ext[15:8] = 8'hA5;
    idle(4);
    rd('h00, 32'h0000_A50C, "R4 level");
    // R9 address map across windows
    wr('h1C, 32'h1);
    chk(32'(pin_out[32]), 32'h1, "R9 bank1 set");
    wr('h14, 32'h1);
    chk(32'(pin_oe[64]), 32'h1, "R9 bank2 dir");
    rd('h14, 32'h1, "R9 bank2 readback");
    wr('h10C, 32'hFFFF_FFFF);
    chk(32'(pin_oe[99:96]), 32'hF, "R9 bank3 dir");
    // R10 unimplemented bits in last bank
    rd('h10C, 32'h0000_000F, "R10 bank3 dir width");
    wr('h130, 32'hFFFF_FFFF);
    rd('h130, 32'h0000_000F, "R10 bank3 rise width");
    // R5 edge detection
    wr('h30, 32'h0005_0000);
    wr('h3C, 32'h0006_0000);
    ext[19:16] = 4'hF;
    idle(4);
    rd('h48, 32'h0005_0000, "R5 rising");
    ext[19:16] = 4'h0;
    idle(4);
    rd('h48, 32'h0007_0000, "R5 falling");
    // R6 sticky, write-one-to-clear
    wr('h48, 32'h0);
    rd('h48, 32'h0007_0000, "R6 zero write");
    wr('h48, 32'h0001_0000);
    rd('h48, 32'h0006_0000, "R6 single clear");
    // R8 masked interrupt
    idle(1);
    chk(32'(irq), 32'h0, "R8 masked off");
    wr('h9C, 32'h0002_0000);
    idle(1);
    chk(32'(irq), 32'h1, "R8 raised");
    wr('h48, 32'h0002_0000);
    idle(1);
    chk(32'(irq), 32'h0, "R8 dropped");
    wr('h48, 32'hFFFF_FFFF);
    rd('h48, 32'h0, "R6 clear all");
    // R7 edge coinciding with clear
    wr('h3C, 32'h0);
    ext[16] = 1'b1;
    idle(4);
    ext[16] = 1'b0;
    idle(4);
    rd('h48, 32'h0001_0000, "R7 primed");
    ext[16] = 1'b1;
    idle(2);
    wr('h48, 32'h0001_0000);
    idle(1);
    rd('h48, 32'h0001_0000, "R7 edge wins");
    // R11 unmapped addresses
    wr('h60, 32'hFFFF_FFFF);
    rd('h60, 32'h0, "R11 hole read");
    rd('h1FC, 32'h0, "R11 high hole");
    rd('h0C, 32'h0000_00FF, "R11 no side effect");
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule